// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Host Flags

This block is a full-duplex asynchronous serial port that drives a transmit line and watches a receive line at the same time. The host hands over one byte at a time through a one-deep transmit holding register and collects received bytes from a single receive data register. Four flags report the host-side state: room to accept a byte, the line has gone quiet after the last frame, a received byte is waiting, and the last received parity was wrong. A fifth flag reports that a received byte replaced one that was never read.

The bit period is set in module clock cycles by a divisor input. The divisor equals the clock frequency over the baud rate, so a 48 MHz clock at 115200 baud takes a divisor of 417. Word length, parity use, parity sense and the number of stop bits are static configuration inputs. A global enable and separate transmitter and receiver enables gate the two halves.

Top module: `uart_xcvr`

## Requirements
- R1: Out of reset, `tx_line` is high, `txe_flag` and `tc_flag` are 1, and `rxr_flag`, `perr_flag`, `ovr_flag` and `rd_data` are 0. While `en_all` or `tx_en` is low, the transmitter returns to idle: `tx_line` is high, and `txe_flag` and `tc_flag` are 1.
- R2: A transmit frame is one low start bit, then the data bits least significant bit first, then the optional parity bit, then one stop bit (`two_stop`=0) or two stop bits (`two_stop`=1), all driven high.
- R3: Every bit on the line lasts exactly `divisor` clock cycles. After the write edge, `tc_flag` reads 1 after 1 + `divisor` x (frame bit count) further rising edges.
- R4: With `par_en`=1 a parity bit is sent. With `par_odd`=0, the data bits plus the parity bit hold an even number of ones. With `par_odd`=1 they hold an odd number. With `par_en`=0 no parity bit is sent.
- R5: A `wr_stb` pulse while `txe_flag` is 1 stores `wr_data` and clears `txe_flag` and `tc_flag`. The byte moves to the shifter on the next edge if the line is idle, and `txe_flag` is set again then. A write while `txe_flag` is 0 is ignored.
- R6: `tc_flag` rises only when the final stop bit has ended and no byte is pending. It is never 1 while `txe_flag` is 0.
- R7: The receiver passes `rx_line` through two flip-flops and confirms a start bit half a bit period after the falling edge. A low pulse that ends before that point does not produce a byte.
- R8: At the centre of the stop bit, the received byte is written to `rd_data` and `rxr_flag` is set.
- R9: A `rd_stb` pulse clears `rxr_flag` and `ovr_flag`, unless a new byte lands in the same cycle.
- R10: With each received byte, `perr_flag` is set to 1 if parity is enabled and the received parity bit does not match the configured sense, and is set to 0 otherwise.
- R11: A byte that arrives while `rxr_flag` is still 1 replaces `rd_data` and sets `ovr_flag`.
- R12: While `en_all` or `rx_en` is low, no byte is received. While `en_all` or `tx_en` is low, writes are ignored.
- R13: `short_word`=0 selects 8 data bits. `short_word`=1 selects 7 data bits: `wr_data[7]` is not sent, and `rd_data[7]` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| en_all | input | 1 | Global enable |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| divisor | input | DIV_W | Bit period in clock cycles, at least 2 |
| short_word | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits |
| wr_stb | input | 1 | Transmit register write strobe |
| wr_data | input | DATA_W | Byte to send |
| rd_stb | input | 1 | Receive register read strobe |
| rd_data | output | DATA_W | Last received byte |
| rx_line | input | 1 | Serial input, asynchronous |
| tx_line | output | 1 | Serial output |
| txe_flag | output | 1 | Transmit register can accept a byte |
| tc_flag | output | 1 | Last frame fully sent |
| rxr_flag | output | 1 | Received byte waiting |
| perr_flag | output | 1 | Parity mismatch on last byte |
| ovr_flag | output | 1 | Unread byte was overwritten |

## Verification
On every cycle, the bound checker enforces the relationships between the flags. These are: complete implies empty, overrun implies data waiting, and a read clears overrun. It also checks that the line is high when complete rises, that the transmitter idles at once when disabled, and that nothing arrives while the receiver is off. Only the bench scenarios can show frame content, bit order, parity value, exact frame duration, mid-bit start rejection, overwrite on overrun and the ignored write while the holding register is full. Each of these needs whole frames to be driven and decoded.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;
  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
  } tx_state_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_t;
endpackage

// File: rtl/uart_bit_timer.sv
module uart_bit_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/uart_sync2.sv
module uart_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RESET_VAL;
      q    <= RESET_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
  import uart_xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              short_word,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_line,
  output logic              txe,
  output logic              tc
);
  localparam int BW = $clog2(DATA_W);
  localparam logic [BW-1:0] LAST_FULL  = BW'(DATA_W - 1);
  localparam logic [BW-1:0] LAST_SHORT = BW'(DATA_W - 2);
  localparam logic [DIV_W-1:0] ONE = 1;

  tx_state_t         state;
  logic [DATA_W-1:0] hold;
  logic [DATA_W-1:0] shreg;
  logic [BW-1:0]     bit_idx;
  logic              par_acc;
  logic              stop_idx;
  logic              bit_done;
  logic              tmr_load;
  logic [BW-1:0]     last_idx;

  assign last_idx = short_word ? LAST_SHORT : LAST_FULL;
  assign tmr_load = enable && (((state == TX_IDLE) && !txe) ||
                               ((state != TX_IDLE) && bit_done));

  uart_bit_timer #(.W(DIV_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (divisor - ONE),
    .done     (bit_done)
  );

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state    <= TX_IDLE;
      tx_line  <= 1'b1;
      txe      <= 1'b1;
      tc       <= 1'b1;
      hold     <= '0;
      shreg    <= '0;
      bit_idx  <= '0;
      par_acc  <= 1'b0;
      stop_idx <= 1'b0;
    end else begin
      if (wr_stb && txe) begin
        hold <= wr_data;
        txe  <= 1'b0;
        tc   <= 1'b0;
      end
      case (state)
        TX_IDLE: begin
          if (!txe) begin
            shreg   <= hold;
            par_acc <= par_odd;
            tx_line <= 1'b0;
            txe     <= 1'b1;
            state   <= TX_START;
          end
        end
        TX_START: begin
          if (bit_done) begin
            tx_line <= shreg[0];
            par_acc <= par_acc ^ shreg[0];
            shreg   <= shreg >> 1;
            bit_idx <= '0;
            state   <= TX_DATA;
          end
        end
        TX_DATA: begin
          if (bit_done) begin
            if (bit_idx == last_idx) begin
              stop_idx <= 1'b0;
              if (par_en) begin
                tx_line <= par_acc;
                state   <= TX_PAR;
              end else begin
                tx_line <= 1'b1;
                state   <= TX_STOP;
              end
            end else begin
              tx_line <= shreg[0];
              par_acc <= par_acc ^ shreg[0];
              shreg   <= shreg >> 1;
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        TX_PAR: begin
          if (bit_done) begin
            tx_line <= 1'b1;
            state   <= TX_STOP;
          end
        end
        TX_STOP: begin
          if (bit_done) begin
            if (two_stop && !stop_idx) begin
              stop_idx <= 1'b1;
            end else begin
              state <= TX_IDLE;
              if (txe && !wr_stb) tc <= 1'b1;
            end
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
  import uart_xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              short_word,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rx_in,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              rxr,
  output logic              perr,
  output logic              ovr
);
  localparam int BW = $clog2(DATA_W);
  localparam logic [BW-1:0] LAST_FULL  = BW'(DATA_W - 1);
  localparam logic [BW-1:0] LAST_SHORT = BW'(DATA_W - 2);
  localparam logic [DIV_W-1:0] ONE = 1;

  rx_state_t         state;
  logic              rxs;
  logic [DATA_W-1:0] shreg;
  logic [BW-1:0]     bit_idx;
  logic              par_bit;
  logic              bit_done;
  logic              tmr_load;
  logic [DIV_W-1:0]  tmr_val;
  logic [BW-1:0]     last_idx;

  assign last_idx = short_word ? LAST_SHORT : LAST_FULL;

  uart_sync2 #(.RESET_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rx_in),
    .q   (rxs)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = divisor - ONE;
    if (enable) begin
      case (state)
        RX_IDLE: begin
          tmr_load = !rxs;
          tmr_val  = (divisor >> 1) - ONE;
        end
        RX_START:         tmr_load = bit_done && !rxs;
        RX_DATA, RX_PAR:  tmr_load = bit_done;
        default:          tmr_load = 1'b0;
      endcase
    end
  end

  uart_bit_timer #(.W(DIV_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (bit_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      shreg   <= '0;
      bit_idx <= '0;
      par_bit <= 1'b0;
      rd_data <= '0;
      rxr     <= 1'b0;
      perr    <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      if (rd_stb) begin
        rxr <= 1'b0;
        ovr <= 1'b0;
      end
      if (!enable) begin
        state <= RX_IDLE;
      end else begin
        case (state)
          RX_IDLE: if (!rxs) state <= RX_START;
          RX_START: begin
            if (bit_done) begin
              if (!rxs) begin
                shreg   <= '0;
                bit_idx <= '0;
                state   <= RX_DATA;
              end else begin
                state <= RX_IDLE;
              end
            end
          end
          RX_DATA: begin
            if (bit_done) begin
              shreg[bit_idx] <= rxs;
              if (bit_idx == last_idx) state <= par_en ? RX_PAR : RX_STOP;
              else bit_idx <= bit_idx + 1'b1;
            end
          end
          RX_PAR: begin
            if (bit_done) begin
              par_bit <= rxs;
              state   <= RX_STOP;
            end
          end
          RX_STOP: begin
            if (bit_done) begin
              rd_data <= shreg;
              rxr     <= 1'b1;
              ovr     <= rxr && !rd_stb;
              perr    <= par_en && (par_bit != ((^shreg) ^ par_odd));
              state   <= RX_IDLE;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_all,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              short_word,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rx_line,
  output logic              tx_line,
  output logic              txe_flag,
  output logic              tc_flag,
  output logic              rxr_flag,
  output logic              perr_flag,
  output logic              ovr_flag
);
  logic tx_on;
  logic rx_on;

  assign tx_on = en_all && tx_en;
  assign rx_on = en_all && rx_en;

  uart_tx_path #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .enable     (tx_on),
    .divisor    (divisor),
    .short_word (short_word),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .two_stop   (two_stop),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .tx_line    (tx_line),
    .txe        (txe_flag),
    .tc         (tc_flag)
  );

  uart_rx_path #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .enable     (rx_on),
    .divisor    (divisor),
    .short_word (short_word),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .rx_in      (rx_line),
    .rd_stb     (rd_stb),
    .rd_data    (rd_data),
    .rxr        (rxr_flag),
    .perr       (perr_flag),
    .ovr        (ovr_flag)
  );
endmodule

// File: rtl/uart_xcvr_chk.sv
module uart_xcvr_chk (
  input logic clk,
  input logic rst,
  input logic en_all,
  input logic tx_en,
  input logic rx_en,
  input logic wr_stb,
  input logic rd_stb,
  input logic tx_line,
  input logic txe_flag,
  input logic tc_flag,
  input logic rxr_flag,
  input logic ovr_flag
);
  // R1: a disabled transmitter idles on the next cycle
  p_tx_off_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !(en_all && tx_en) |=> (tx_line && txe_flag && tc_flag));

  // R5: an accepted write clears both transmit flags
  p_write_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (en_all && tx_en && wr_stb && txe_flag) |=> (!txe_flag && !tc_flag));

  // R6: complete implies empty
  p_tc_needs_txe_r6: assert property (@(posedge clk) disable iff (rst)
    tc_flag |-> txe_flag);

  // R6: complete rises with the line back at idle level
  p_tc_line_high_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(tc_flag) |-> tx_line);

  // R9: a read leaves no overrun behind
  p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> !ovr_flag);

  // R11: overrun only exists with data waiting
  p_ovr_needs_rxr_r11: assert property (@(posedge clk) disable iff (rst)
    ovr_flag |-> rxr_flag);

  // R12: nothing arrives while the receiver is off
  p_rx_off_r12: assert property (@(posedge clk) disable iff (rst)
    !(en_all && rx_en) |=> !$rose(rxr_flag));
endmodule

bind uart_xcvr uart_xcvr_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .en_all   (en_all),
  .tx_en    (tx_en),
  .rx_en    (rx_en),
  .wr_stb   (wr_stb),
  .rd_stb   (rd_stb),
  .tx_line  (tx_line),
  .txe_flag (txe_flag),
  .tc_flag  (tc_flag),
  .rxr_flag (rxr_flag),
  .ovr_flag (ovr_flag)
);

// File: tb/uart_xcvr_bench.sv
`timescale 1ns/1ps
module uart_xcvr_bench;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_all = 1'b1, tx_en = 1'b1, rx_en = 1'b1;
  logic [DIV_W-1:0] divisor = 16'd5;
  logic short_word = 1'b0, par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic wr_stb = 1'b0, rd_stb = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic rx_line = 1'b1;
  logic tx_line, txe_flag, tc_flag, rxr_flag, perr_flag, ovr_flag;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_xcvr #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_uart_xcvr (
    .clk(clk), .rst(rst), .en_all(en_all), .tx_en(tx_en), .rx_en(rx_en),
    .divisor(divisor), .short_word(short_word), .par_en(par_en),
    .par_odd(par_odd), .two_stop(two_stop), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
    .rx_line(rx_line), .tx_line(tx_line), .txe_flag(txe_flag),
    .tc_flag(tc_flag), .rxr_flag(rxr_flag), .perr_flag(perr_flag),
    .ovr_flag(ovr_flag)
  );

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mask_word(input logic [7:0] d, input logic sw);
    return sw ? (d & 8'h7F) : d;
  endfunction

  function automatic logic exp_parity(input logic [7:0] d, input logic sw, input logic odd);
    return (^mask_word(d, sw)) ^ odd;
  endfunction

  function automatic int frame_bits();
    return 1 + (short_word ? 7 : 8) + (par_en ? 1 : 0) + (two_stop ? 2 : 1);
  endfunction

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk); wr_stb = 1'b1; wr_data = d;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  // decode one frame from tx_line, sampling at bit centres
  task automatic decode_tx(output logic [7:0] d, output logic pb, output logic stops_ok,
                           output logic found);
    int n = 0;
    int nb = short_word ? 7 : 8;
    d = '0; pb = 1'b0; stops_ok = 1'b1; found = 1'b0;
    while (tx_line && n < 5000) begin @(negedge clk); n++; end
    if (!tx_line) begin
      found = 1'b1;
      repeat (int'(divisor) / 2) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
        repeat (int'(divisor)) @(negedge clk);
        d[i] = tx_line;
      end
      if (par_en) begin
        repeat (int'(divisor)) @(negedge clk);
        pb = tx_line;
      end
      for (int s = 0; s < (two_stop ? 2 : 1); s++) begin
        repeat (int'(divisor)) @(negedge clk);
        if (!tx_line) stops_ok = 1'b0;
      end
    end
  endtask

  task automatic send_rx(input logic [7:0] d, input logic bad_par);
    int nb = short_word ? 7 : 8;
    @(negedge clk); rx_line = 1'b0;
    repeat (int'(divisor)) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rx_line = d[i];
      repeat (int'(divisor)) @(negedge clk);
    end
    if (par_en) begin
      rx_line = exp_parity(d, short_word, par_odd) ^ bad_par;
      repeat (int'(divisor)) @(negedge clk);
    end
    rx_line = 1'b1;
    repeat (int'(divisor) * (two_stop ? 2 : 1)) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_tc();
    int n = 0;
    while (!tc_flag && n < 5000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, a, b;
    logic pb, sok, fnd;
    int cnt;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(tx_line, 1, "R1 tx_line");
    check(txe_flag, 1, "R1 txe");
    check(tc_flag, 1, "R1 tc");
    check(rxr_flag, 0, "R1 rxr");
    check(perr_flag, 0, "R1 perr");
    check(ovr_flag, 0, "R1 ovr");
    check(rd_data, 0, "R1 rd_data");

    // R3 / R5: exact frame duration and flag sequence, 8N1, divisor 5
    divisor = 16'd5;
    wr_byte(8'hA5);
    check(txe_flag, 0, "R5 txe cleared by write");
    check(tc_flag, 0, "R5 tc cleared by write");
    @(negedge clk);
    check(txe_flag, 1, "R5 txe set on load");
    check(tx_line, 0, "R2 start bit low");
    cnt = 1;
    while (!tc_flag && cnt < 2000) begin @(negedge clk); cnt++; end
    check(cnt, 1 + 5 * frame_bits(), "R3 frame duration");
    check(tx_line, 1, "R6 line high at complete");

    // random frames in both directions
    for (int it = 0; it < 24; it++) begin
      logic bad;
      divisor = 16'(4 + ($urandom % 8));
      short_word = 1'($urandom); par_en = 1'($urandom);
      par_odd = 1'($urandom); two_stop = 1'($urandom);
      d = 8'($urandom);
      wr_byte(d);
      decode_tx(a, pb, sok, fnd);
      check(fnd, 1, "R2 frame seen");
      check(a, mask_word(d, short_word), "R2 R13 tx data");
      if (par_en) check(pb, exp_parity(d, short_word, par_odd), "R4 tx parity");
      check(sok, 1, "R2 stop bits high");
      wait_tc();
      check(tc_flag, 1, "R6 tc after frame");
      bad = par_en && (($urandom % 4) == 0);
      d = 8'($urandom);
      send_rx(d, bad);
      check(rxr_flag, 1, "R8 rxr set");
      check(rd_data, mask_word(d, short_word), "R8 R13 rx data");
      check(perr_flag, bad, "R10 parity flag");
      rd_pulse();
      check(rxr_flag, 0, "R9 read clears rxr");
    end

    // R5: write while holding register full is ignored
    divisor = 16'd6; short_word = 0; par_en = 1; par_odd = 0; two_stop = 0;
    fork
      begin
        decode_tx(a, pb, sok, fnd);
        decode_tx(b, pb, sok, fnd);
      end
      begin
        wr_byte(8'h3C);
        wr_byte(8'hC3);
        check(txe_flag, 0, "R5 holding full");
        wr_byte(8'h99);
      end
    join
    check(a, 8'h3C, "R5 first byte");
    check(b, 8'hC3, "R5 second byte");
    wait_tc();
    cnt = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (!tx_line) cnt++; end
    check(cnt, 0, "R5 ignored write not sent");

    // R11 overrun then R9 clear
    par_en = 0;
    send_rx(8'h11, 1'b0);
    send_rx(8'h77, 1'b0);
    check(ovr_flag, 1, "R11 overrun set");
    check(rd_data, 8'h77, "R11 data replaced");
    rd_pulse();
    check(ovr_flag, 0, "R9 read clears ovr");
    check(rxr_flag, 0, "R9 read clears rxr");

    // R7: short low glitch rejected, then a real frame accepted
    divisor = 16'd10;
    @(negedge clk); rx_line = 1'b0;
    repeat (2) @(negedge clk); rx_line = 1'b1;
    repeat (40) @(negedge clk);
    check(rxr_flag, 0, "R7 glitch rejected");
    send_rx(8'h5E, 1'b0);
    check(rxr_flag, 1, "R7 frame after glitch");
    check(rd_data, 8'h5E, "R7 data after glitch");
    rd_pulse();

    // R12: receiver and transmitter disabled
    rx_en = 0;
    send_rx(8'h42, 1'b0);
    check(rxr_flag, 0, "R12 rx disabled");
    rx_en = 1;
    en_all = 0;
    wr_byte(8'h00);
    cnt = 0;
    for (int i = 0; i < 150; i++) begin @(negedge clk); if (!tx_line) cnt++; end
    check(cnt, 0, "R12 tx disabled line idle");
    check(txe_flag, 1, "R1 txe while disabled");
    en_all = 1;
    @(negedge clk);
    check(tx_line, 1, "R12 no frame after enable");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule